// File: doc/BRIEF.md
# Event Trace Timing Comparator

The comparator takes two streams of architectural event records, one produced by a model under test and one by a reference. Each record has a cycle stamp, a program counter and an event type. The i-th record of one stream is matched with the i-th record of the other. Both records of a pair are accepted in the same cycle. The pair passes when the program counters agree and the two cycle stamps lie within a programmable tolerance of each other.

Every failing pair produces a one-cycle report. The report gives the pair's position in the trace, the reasons it failed and the reference record's event type. A saturating counter tallies the failing pairs. Each stream closes with a terminator beat. When both terminators arrive together the trace ends cleanly. When only one stream has ended, the block reports one extra failure for the length mismatch. In both cases the comparator raises done and stops accepting beats until reset.

Top module: `trace_cmp_top`

## Requirements
- R1: A pair is accepted only in a cycle where both inputs are valid and done is low. In that cycle both ready outputs are high. While the reference input is not valid, the model ready output stays low and nothing is consumed.
- R2: A data pair whose program counters differ sets the PC-mismatch bit of its report.
- R3: Let gap be the absolute difference of the two 32-bit cycle stamps, computed without wraparound. The timing-mismatch bit is set when gap is greater than the 16-bit tolerance. A gap equal to the tolerance passes.
- R4: A failing pair produces a report in the cycle after its accepting edge. The report carries the 0-based pair index and the event type. The event type comes from the reference record, or from the model record when the reference beat is a terminator. Event type codes are: 0 pipeline, 1 memory enqueue, 2 memory dequeue.
- R5: A data pair that matches in program counter and timing produces no report and leaves the counter unchanged. The pair index still advances.
- R6: The violation counter rises by one for each failing pair and holds at 2^CNT_W-1 once it gets there.
- R7: Terminators on both streams in the same pair raise done and produce no report.
- R8: When a terminator meets a data record, the block reports with the length-mismatch bit set and the current pair index, and raises done.
- R9: Once done is high, both ready outputs stay low, no report is produced and the counter holds, until reset.
- R10: A synchronous active-high reset clears the counter, done, the pair index and the report valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tol_i | input | 16 | Cycle stamp tolerance |
| m_valid | input | 1 | Model beat valid |
| m_ready | output | 1 | Model beat accepted |
| m_eot | input | 1 | Model beat is a terminator |
| m_stamp | input | 32 | Model cycle stamp |
| m_pc | input | PC_W | Model program counter |
| m_evt | input | 2 | Model event type |
| r_valid | input | 1 | Reference beat valid |
| r_ready | output | 1 | Reference beat accepted |
| r_eot | input | 1 | Reference beat is a terminator |
| r_stamp | input | 32 | Reference cycle stamp |
| r_pc | input | PC_W | Reference program counter |
| r_evt | input | 2 | Reference event type |
| vio_valid | output | 1 | Report valid for one cycle |
| vio_idx | output | IDX_W | Pair index of the report |
| vio_pc_bad | output | 1 | Program counter mismatch |
| vio_time_bad | output | 1 | Timing outside tolerance |
| vio_len_bad | output | 1 | Trace length mismatch |
| vio_evt | output | 2 | Event type of the failing pair |
| vio_count | output | CNT_W | Saturating violation count |
| done | output | 1 | Trace finished |

## Verification
The bench sweeps the signed stamp offset from -6 to +6 for tolerances of 0, 2 and 5. For each offset it sends pairs with matching and with differing program counters. This shows whether the pass boundary sits exactly at the tolerance on both sides of zero, and keeps timing failures apart from program counter failures. Stamps at the extremes of the 32-bit range then expose any wraparound in the gap. A narrow counter is driven into saturation within the sweep. Three endings are tried: both terminators together, the model stream ending first and the reference stream ending first. Together they separate a clean finish from the two length mismatches and check which event type each reports.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int STAMP_W = 32;
  localparam int TOL_W   = 16;
  localparam int EVT_W   = 2;

  typedef enum logic [EVT_W-1:0] {
    EV_PIPE      = 2'd0,
    EV_MEM_ENQ   = 2'd1,
    EV_MEM_DEQ   = 2'd2,
    EV_SPARE     = 2'd3
  } trc_evt_e;

  // Distance between two stamps, no wraparound.
  function automatic logic [STAMP_W-1:0] stamp_gap(input logic [STAMP_W-1:0] x,
                                                   input logic [STAMP_W-1:0] y);
    if (x >= y) return x - y;
    else        return y - x;
  endfunction

  function automatic logic gap_too_wide(input logic [STAMP_W-1:0] gap,
                                        input logic [TOL_W-1:0]   tol);
    return gap > {{(STAMP_W-TOL_W){1'b0}}, tol};
  endfunction
endpackage

// File: rtl/trc_join.sv
module trc_join (
  input  logic m_valid,
  input  logic r_valid,
  input  logic halt,
  output logic m_ready,
  output logic r_ready,
  output logic fire
);
  assign m_ready = r_valid & ~halt;
  assign r_ready = m_valid & ~halt;
  assign fire    = m_valid & r_valid & ~halt;
endmodule

// File: rtl/trc_judge.sv
module trc_judge
  import trc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic [TOL_W-1:0]   tol,
  input  logic               m_eot,
  input  logic [STAMP_W-1:0] m_stamp,
  input  logic [PC_W-1:0]    m_pc,
  input  logic [EVT_W-1:0]   m_evt,
  input  logic               r_eot,
  input  logic [STAMP_W-1:0] r_stamp,
  input  logic [PC_W-1:0]    r_pc,
  input  logic [EVT_W-1:0]   r_evt,
  output logic               pc_bad,
  output logic               time_bad,
  output logic               len_bad,
  output logic               both_end,
  output logic               any_bad,
  output logic [EVT_W-1:0]   rep_evt
);
  logic               both_data;
  logic [STAMP_W-1:0] gap;

  assign both_data = ~m_eot & ~r_eot;
  assign both_end  = m_eot & r_eot;
  assign gap       = stamp_gap(m_stamp, r_stamp);
  assign pc_bad    = both_data & (m_pc != r_pc);
  assign time_bad  = both_data & gap_too_wide(gap, tol);
  assign len_bad   = m_eot ^ r_eot;
  assign any_bad   = pc_bad | time_bad | len_bad;
  assign rep_evt   = r_eot ? m_evt : r_evt;
endmodule

// File: rtl/trc_satcnt.sv
module trc_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  localparam logic [W-1:0] TOP = '1;
  assign at_max = (cnt == TOP);
  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (inc && !at_max) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/trace_cmp_top.sv
module trace_cmp_top
  import trc_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int IDX_W = 16,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TOL_W-1:0]   tol_i,
  input  logic               m_valid,
  output logic               m_ready,
  input  logic               m_eot,
  input  logic [STAMP_W-1:0] m_stamp,
  input  logic [PC_W-1:0]    m_pc,
  input  logic [EVT_W-1:0]   m_evt,
  input  logic               r_valid,
  output logic               r_ready,
  input  logic               r_eot,
  input  logic [STAMP_W-1:0] r_stamp,
  input  logic [PC_W-1:0]    r_pc,
  input  logic [EVT_W-1:0]   r_evt,
  output logic               vio_valid,
  output logic [IDX_W-1:0]   vio_idx,
  output logic               vio_pc_bad,
  output logic               vio_time_bad,
  output logic               vio_len_bad,
  output logic [EVT_W-1:0]   vio_evt,
  output logic [CNT_W-1:0]   vio_count,
  output logic               done
);
  // named internal events
  logic             fire;
  logic             pc_bad, time_bad, len_bad, both_end, any_bad;
  logic [EVT_W-1:0] rep_evt;
  logic             cnt_full;
  logic             bump;
  logic             finish;
  logic [IDX_W-1:0] pair_idx;

  trc_join u_join (
    .m_valid (m_valid),
    .r_valid (r_valid),
    .halt    (done),
    .m_ready (m_ready),
    .r_ready (r_ready),
    .fire    (fire)
  );

  trc_judge #(.PC_W(PC_W)) u_judge (
    .tol      (tol_i),
    .m_eot    (m_eot),
    .m_stamp  (m_stamp),
    .m_pc     (m_pc),
    .m_evt    (m_evt),
    .r_eot    (r_eot),
    .r_stamp  (r_stamp),
    .r_pc     (r_pc),
    .r_evt    (r_evt),
    .pc_bad   (pc_bad),
    .time_bad (time_bad),
    .len_bad  (len_bad),
    .both_end (both_end),
    .any_bad  (any_bad),
    .rep_evt  (rep_evt)
  );

  assign bump   = fire & any_bad;
  assign finish = fire & (len_bad | both_end);

  trc_satcnt #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .inc    (bump),
    .cnt    (vio_count),
    .at_max (cnt_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vio_valid    <= 1'b0;
      vio_idx      <= '0;
      vio_pc_bad   <= 1'b0;
      vio_time_bad <= 1'b0;
      vio_len_bad  <= 1'b0;
      vio_evt      <= '0;
      done         <= 1'b0;
      pair_idx     <= '0;
    end else begin
      vio_valid <= bump;
      if (bump) begin
        vio_idx      <= pair_idx;
        vio_pc_bad   <= pc_bad;
        vio_time_bad <= time_bad;
        vio_len_bad  <= len_bad;
        vio_evt      <= rep_evt;
      end
      if (finish)    done     <= 1'b1;
      else if (fire) pair_idx <= pair_idx + 1'b1;
    end
  end
endmodule

// File: rtl/trc_cmp_chk.sv
module trc_cmp_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             m_valid,
  input logic             r_valid,
  input logic             m_ready,
  input logic             r_ready,
  input logic             fire,
  input logic             vio_valid,
  input logic             vio_pc_bad,
  input logic             vio_time_bad,
  input logic             vio_len_bad,
  input logic [CNT_W-1:0] vio_count,
  input logic             done
);
  localparam logic [CNT_W-1:0] TOP = '1;

  p_ready_pair_r1: assert property (@(posedge clk) disable iff (rst)
    m_ready |-> r_valid);
  p_ready_both_r1: assert property (@(posedge clk) disable iff (rst)
    (m_ready && m_valid) |-> r_ready);
  p_vio_cause_r4: assert property (@(posedge clk) disable iff (rst)
    vio_valid |-> (vio_pc_bad || vio_time_bad || vio_len_bad));
  p_vio_after_fire_r4: assert property (@(posedge clk) disable iff (rst)
    vio_valid |-> $past(fire));
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    (vio_valid && $past(vio_count) != TOP) |-> vio_count == CNT_W'($past(vio_count) + 1'b1));
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (vio_count == TOP) |=> (vio_count == TOP));
  p_len_done_r8: assert property (@(posedge clk) disable iff (rst)
    (vio_valid && vio_len_bad) |-> done);
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  p_done_block_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!m_ready && !r_ready));
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (vio_count == '0 && !done && !vio_valid));
endmodule

bind trace_cmp_top trc_cmp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .m_valid      (m_valid),
  .r_valid      (r_valid),
  .m_ready      (m_ready),
  .r_ready      (r_ready),
  .fire         (fire),
  .vio_valid    (vio_valid),
  .vio_pc_bad   (vio_pc_bad),
  .vio_time_bad (vio_time_bad),
  .vio_len_bad  (vio_len_bad),
  .vio_count    (vio_count),
  .done         (done)
);

// File: tb/sim_trace_cmp_top.sv
module sim_trace_cmp_top;
  localparam int PCW = 16;
  localparam int IW  = 16;
  localparam int CW  = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] tol_i = '0;
  logic m_valid = 0, m_eot = 0, r_valid = 0, r_eot = 0;
  logic [31:0] m_stamp = '0, r_stamp = '0;
  logic [PCW-1:0] m_pc = '0, r_pc = '0;
  logic [1:0] m_evt = '0, r_evt = '0;
  logic m_ready, r_ready, vio_valid, vio_pc_bad, vio_time_bad, vio_len_bad, done;
  logic [IW-1:0] vio_idx;
  logic [1:0] vio_evt;
  logic [CW-1:0] vio_count;

  int checks = 0;
  int fails = 0;
  int exp_cnt = 0;
  int exp_idx = 0;
  bit exp_done = 0;

  always #2.5 clk = ~clk;

  trace_cmp_top #(.PC_W(PCW), .IDX_W(IW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .tol_i(tol_i),
    .m_valid(m_valid), .m_ready(m_ready), .m_eot(m_eot), .m_stamp(m_stamp), .m_pc(m_pc), .m_evt(m_evt),
    .r_valid(r_valid), .r_ready(r_ready), .r_eot(r_eot), .r_stamp(r_stamp), .r_pc(r_pc), .r_evt(r_evt),
    .vio_valid(vio_valid), .vio_idx(vio_idx), .vio_pc_bad(vio_pc_bad), .vio_time_bad(vio_time_bad),
    .vio_len_bad(vio_len_bad), .vio_evt(vio_evt), .vio_count(vio_count), .done(done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; m_valid = 0; r_valid = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    exp_cnt = 0; exp_idx = 0; exp_done = 0;
    @(negedge clk);
    chk("R10 count", 64'(vio_count), 64'd0);
    chk("R10 done", 64'(done), 64'd0);
    chk("R10 vio_valid", 64'(vio_valid), 64'd0);
  endtask

  task automatic pair(input logic [31:0] sa, input logic [31:0] sb,
                      input logic [PCW-1:0] pa, input logic [PCW-1:0] pb,
                      input logic [1:0] ea, input logic [1:0] eb,
                      input logic ta, input logic tb);
    bit vio, pcb, tmb, lnb;
    longint gap;
    logic [1:0] ev;
    m_stamp = sa; r_stamp = sb; m_pc = pa; r_pc = pb;
    m_evt = ea; r_evt = eb; m_eot = ta; r_eot = tb;
    m_valid = 1; r_valid = 1;
    #1;
    chk("R1/R9 m_ready", 64'(m_ready), 64'(!exp_done));
    chk("R1/R9 r_ready", 64'(r_ready), 64'(!exp_done));
    @(posedge clk);
    @(negedge clk);
    m_valid = 0; r_valid = 0;
    vio = 0; pcb = 0; tmb = 0; lnb = 0; ev = tb ? ea : eb;
    if (!exp_done) begin
      if (ta && tb) begin
        exp_done = 1;
      end else if (ta != tb) begin
        vio = 1; lnb = 1; exp_done = 1;
      end else begin
        gap = longint'(sa) - longint'(sb);
        if (gap < 0) gap = -gap;
        pcb = (pa != pb);
        tmb = (gap > longint'(tol_i));
        vio = pcb | tmb;
      end
    end
    chk("R4/R5/R9 vio_valid", 64'(vio_valid), 64'(vio));
    if (vio) begin
      chk("R4 vio_idx", 64'(vio_idx), 64'(exp_idx));
      chk("R4 vio_evt", 64'(vio_evt), 64'(ev));
      chk("R2 pc bit", 64'(vio_pc_bad), 64'(pcb));
      chk("R3 time bit", 64'(vio_time_bad), 64'(tmb));
      chk("R8 len bit", 64'(vio_len_bad), 64'(lnb));
      if (exp_cnt < CMAX) exp_cnt++;
    end
    if (!exp_done) exp_idx++;
    chk("R6 count", 64'(vio_count), 64'(exp_cnt));
    chk("R7/R8 done", 64'(done), 64'(exp_done));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: only one side valid -> nothing consumed
    @(negedge clk);
    m_valid = 1; m_eot = 0;
    #1 chk("R1 m_ready without ref", 64'(m_ready), 64'd0);
    @(negedge clk);
    m_valid = 0;
    chk("R1 nothing consumed", 64'(vio_valid), 64'd0);
    // R2/R3/R5 sweep
    for (int ti = 0; ti < 3; ti++) begin
      tol_i = (ti == 0) ? 16'd0 : (ti == 1) ? 16'd2 : 16'd5;
      for (int d = -6; d <= 6; d++) begin
        for (int pm = 0; pm < 2; pm++) begin
          pair(32'(1000 + d), 32'd1000, 16'h0100, (pm != 0) ? 16'h0104 : 16'h0100,
               2'((d + 6) % 3), 2'((d + 7) % 3), 1'b0, 1'b0);
        end
      end
    end
    // R3 no wraparound at the stamp extremes
    tol_i = 16'hFFFF;
    pair(32'h0, 32'hFFFF_FFFF, 16'h20, 16'h20, 2'd0, 2'd1, 0, 0);
    pair(32'hFFFF_FFFF, 32'hFFFF_0000, 16'h21, 16'h21, 2'd1, 2'd2, 0, 0);
    pair(32'hFFFF_FFFF, 32'hFFFE_FFFF, 16'h22, 16'h22, 2'd2, 2'd0, 0, 0);
    chk("R6 saturated", 64'(vio_count), 64'(CMAX));
    // R7 clean end, then R9 blocked
    pair(32'd0, 32'd0, 16'h0, 16'h0, 2'd0, 2'd0, 1, 1);
    chk("R7 no report", 64'(vio_valid), 64'd0);
    pair(32'd5, 32'd900, 16'h1, 16'h2, 2'd0, 2'd0, 0, 0);
    // R8 model ends first
    do_reset();
    tol_i = 16'd1;
    pair(32'd10, 32'd11, 16'h4, 16'h4, 2'd0, 2'd0, 0, 0);
    pair(32'd20, 32'd30, 16'h5, 16'h5, 2'd1, 2'd1, 0, 0);
    pair(32'd0, 32'd40, 16'h0, 16'h6, 2'd0, 2'd2, 1, 0);
    pair(32'd1, 32'd1, 16'h0, 16'h0, 2'd0, 2'd0, 0, 0);
    // R8 reference ends first
    do_reset();
    pair(32'd7, 32'd7, 16'h9, 16'h9, 2'd2, 2'd2, 0, 0);
    pair(32'd8, 32'd0, 16'hA, 16'h0, 2'd1, 2'd0, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule